// File: doc/BRIEF.md
# Floppy Controller Register and Interrupt Unit

This unit is the host-visible register file of a floppy disk controller. A byte-wide host port reaches sixteen registers spaced sixteen bytes apart. The control byte that steers the seek and transfer engines cannot be written directly. One address clears the bits written as ones, and a second address sets them. Reads of that second address return a live status byte.

The unit latches event pulses from the disk data path, the stepper and the transfer logic as interrupt causes. It masks them with an enable register and drives one interrupt line. Data-path faults collect in an error register that clears when read. A countdown register decrements once per microsecond, stops at zero and raises its own cause when it expires. The setup register carries a software reset bit that returns the control, cause, enable and error state to zero.

Top module: `fdc_regbank`

## Requirements
- R1: The register index is host_addr[7:4]. Bits host_addr[3:0] are ignored. Index order: 0 data, 1 timer, 2 error, 3 mode, 4 select, 5 setup, 6 control-clear, 7 control-set/status, 8 causes, 9 step count, 10 current track, 11 current sector, 12 gap length, 13 target sector, 14 sector count, 15 cause enable. A read strobe in cycle n puts the value on host_rdata after that edge, and the value holds until the next read.
- R2: A write of ones to index 7 sets those control bits, and a write of ones to index 6 clears them. ctrl_out shows the result one cycle later. A read of index 6 returns the control byte. Control bit 0x01 is the interrupt gate.
- R3: Event pulses latch cause bits: 0x20 error, 0x10 data changed, 0x08 transfer done, 0x04 sector seen, 0x02 seek done, 0x01 timer expired. A read of index 8 returns the causes and clears them. A cause that arrives in the same cycle as that read stays latched for the next read.
- R4: irq is high exactly while control bit 0x01 is set and the causes ANDed with the enable register (index 15, low six bits) are nonzero. Writes to index 8 have no effect.
- R5: err_event bits 0x80, 0x40, 0x04 and 0x01 set the matching bits of the error register (index 2), and the other bits are dropped. Any accepted error bit also latches cause 0x20. A read of index 2 returns the error byte and clears it.
- R6: A write to index 1 loads the counter and restarts its microsecond prescaler. The counter decrements every CLKS_PER_US clocks, stops at zero, and latches cause 0x01 once on the step from 1 to 0. Loading zero raises no cause. Reads return the current count.
- R7: A read of index 7 returns the status byte: 0x80 fifo_one, 0x40 fifo_two, 0x20 error register nonzero, 0x08 sense_line, 0x02 a cause is enabled and pending, 0x01 mark_byte. All other bits read as 0.
- R8: A write to index 5 with bit 0x80 set clears control, causes, cause enable and error, and this takes priority over events in the same cycle. The setup register keeps the low seven bits, and bit 0x80 reads back as 0.
- R9: The data, mode, select, step count, track, sector, gap, target sector and sector count registers read back the last value written. select_out and setup_out mirror the select and setup registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 write, 0 read |
| host_addr | input | 8 | Byte address; bits 7:4 pick the register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| ev_data_changed | input | 1 | Pulse: data changed |
| ev_xfer_done | input | 1 | Pulse: transfer finished |
| ev_sector_seen | input | 1 | Pulse: sector header seen |
| ev_seek_done | input | 1 | Pulse: seek finished |
| err_event | input | 8 | Pulse mask of data-path faults |
| fifo_one | input | 1 | FIFO holds one byte |
| fifo_two | input | 1 | FIFO holds two bytes |
| sense_line | input | 1 | Selected drive sense signal |
| mark_byte | input | 1 | Current byte is a mark |
| ctrl_out | output | 8 | Control byte to the engines |
| select_out | output | 8 | Drive select register |
| setup_out | output | 8 | Setup register |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or stale cause bit shows up on irq on the first cycle after the event or read. A lost cause shows as a missing bit on the next read of index 8. A control alias that is decoded wrongly changes ctrl_out one cycle after the write. A prescaler that is off by one moves the timer interrupt edge by at least a clock, which the edge-exact irq checks catch. A software reset that misses a register leaves a nonzero readback or a high irq right after the setup write.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;

    typedef enum logic [3:0] {
        RI_DATA    = 4'd0,
        RI_TIMER   = 4'd1,
        RI_ERROR   = 4'd2,
        RI_MODE    = 4'd3,
        RI_SELECT  = 4'd4,
        RI_SETUP   = 4'd5,
        RI_CTL_CLR = 4'd6,
        RI_CTL_SET = 4'd7,
        RI_CAUSE   = 4'd8,
        RI_NSTEP   = 4'd9,
        RI_TRACK   = 4'd10,
        RI_SECT    = 4'd11,
        RI_GAPLEN  = 4'd12,
        RI_TSECT   = 4'd13,
        RI_SCOUNT  = 4'd14,
        RI_CAUSEEN = 4'd15
    } reg_idx_e;

    localparam int CAUSE_W = 6;

    localparam int CB_TIMER  = 0;
    localparam int CB_SEEK   = 1;
    localparam int CB_SECTOR = 2;
    localparam int CB_XFER   = 3;
    localparam int CB_DCHG   = 4;
    localparam int CB_ERR    = 5;

    localparam logic [7:0] ERR_KEEP_MASK = 8'hC5;
    localparam int         SETUP_RST_BIT = 7;
    localparam int         CTL_GATE_BIT  = 0;

endpackage

// File: rtl/fdc_ctrl_reg.sv
module fdc_ctrl_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         swrst,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_o
);

    typedef struct packed {
        logic [W-1:0] ctrl;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) st_d.ctrl = st_q.ctrl | wdata;
        if (clr_we) st_d.ctrl = st_q.ctrl & ~wdata;
        if (swrst)  st_d.ctrl = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;

    assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !swrst) |=> ((ctrl_o & $past(wdata)) == $past(wdata)));

    assert_clr_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((ctrl_o & $past(wdata)) == '0));

    assert_swreset_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (ctrl_o == '0));

endmodule

// File: rtl/fdc_irq_unit.sv
module fdc_irq_unit
    import fdc_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swrst,
    input  logic               en_we,
    input  logic [7:0]         wdata,
    input  logic               rd_cause,
    input  logic               rd_err,
    input  logic [CAUSE_W-2:0] ev_cause,
    input  logic [7:0]         err_evt,
    input  logic               irq_gate,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [CAUSE_W-1:0] en_o,
    output logic [7:0]         err_o,
    output logic               pending_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [CAUSE_W-1:0] en;
        logic [7:0]         err;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [7:0]         err_acc;
    logic [CAUSE_W-1:0] cause_in;

    always_comb begin
        err_acc  = err_evt & ERR_KEEP_MASK;
        cause_in = {(|err_acc), ev_cause};
        st_d     = st_q;
        st_d.cause = (rd_cause ? '0 : st_q.cause) | cause_in;
        st_d.err   = (rd_err   ? '0 : st_q.err)   | err_acc;
        if (en_we) st_d.en = wdata[CAUSE_W-1:0];
        if (swrst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o   = st_q.cause;
    assign en_o      = st_q.en;
    assign err_o     = st_q.err;
    assign pending_o = |(st_q.cause & st_q.en);
    assign irq_o     = irq_gate & pending_o;

    assert_cause_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cause && !swrst) |=> ((cause_o & $past(cause_in)) == $past(cause_in)));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cause && (ev_cause == '0) && ((err_evt & ERR_KEEP_MASK) == '0)) |=> (cause_o == '0));

    assert_err_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err && ((err_evt & ERR_KEEP_MASK) == '0)) |=> (err_o == '0));

    assert_err_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_o & ~ERR_KEEP_MASK) == '0));

endmodule

// File: rtl/fdc_usec_timer.sv
module fdc_usec_timer #(
    parameter int CLKS_PER_US = 8,
    parameter int W           = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count_o,
    output logic         expire_o
);

    localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_US - 1);

    typedef struct packed {
        logic [W-1:0]  count;
        logic [PW-1:0] pre;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d     = st_q;
        tick     = (st_q.count != '0) && (st_q.pre == PRE_LAST);
        expire_o = 1'b0;
        if (load) begin
            st_d.count = wdata;
            st_d.pre   = '0;
        end else if (st_q.count != '0) begin
            if (tick) begin
                st_d.pre   = '0;
                st_d.count = st_q.count - 1'b1;
                expire_o   = (st_q.count == W'(1));
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end else begin
            st_d.pre = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    assert_stop_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o == '0) && !load) |=> (count_o == '0));

    assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o != '0) && !load) |=>
            ((count_o == $past(count_o)) || (count_o == W'($past(count_o) - 1'b1))));

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_o == $past(wdata)));

endmodule

// File: rtl/fdc_regbank.sv
module fdc_regbank
    import fdc_regs_pkg::*;
#(
    parameter int CLKS_PER_US = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       ev_data_changed,
    input  logic       ev_xfer_done,
    input  logic       ev_sector_seen,
    input  logic       ev_seek_done,
    input  logic [7:0] err_event,
    input  logic       fifo_one,
    input  logic       fifo_two,
    input  logic       sense_line,
    input  logic       mark_byte,
    output logic [7:0] ctrl_out,
    output logic [7:0] select_out,
    output logic [7:0] setup_out,
    output logic       irq
);

    typedef struct packed {
        logic [7:0] data;
        logic [7:0] mode;
        logic [7:0] sel;
        logic [7:0] setup;
        logic [7:0] nstep;
        logic [7:0] track;
        logic [7:0] sect;
        logic [7:0] gaplen;
        logic [7:0] tsect;
        logic [7:0] scount;
        logic [7:0] rdata;
    } bank_st_t;

    bank_st_t st_d, st_q;

    reg_idx_e           idx;
    logic               wr_hit, rd_hit, swrst;
    logic [7:0]         ctrl_w, count_w, err_w, status_w, rd_mux;
    logic [CAUSE_W-1:0] cause_w, en_w;
    logic [CAUSE_W-2:0] ev_vec;
    logic               pending_w, expire_w;
    logic               addr_lo_unused;

    assign idx            = reg_idx_e'(host_addr[7:4]);
    assign addr_lo_unused = ^host_addr[3:0];
    assign wr_hit         = host_sel & host_wr;
    assign rd_hit         = host_sel & ~host_wr;
    assign swrst          = wr_hit && (idx == RI_SETUP) && host_wdata[SETUP_RST_BIT];

    always_comb begin
        ev_vec            = '0;
        ev_vec[CB_TIMER]  = expire_w;
        ev_vec[CB_SEEK]   = ev_seek_done;
        ev_vec[CB_SECTOR] = ev_sector_seen;
        ev_vec[CB_XFER]   = ev_xfer_done;
        ev_vec[CB_DCHG]   = ev_data_changed;
    end

    fdc_ctrl_reg #(.W(8)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_hit && (idx == RI_CTL_SET)),
        .clr_we (wr_hit && (idx == RI_CTL_CLR)),
        .swrst  (swrst),
        .wdata  (host_wdata),
        .ctrl_o (ctrl_w)
    );

    fdc_usec_timer #(.CLKS_PER_US(CLKS_PER_US), .W(8)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_hit && (idx == RI_TIMER)),
        .wdata    (host_wdata),
        .count_o  (count_w),
        .expire_o (expire_w)
    );

    fdc_irq_unit u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .swrst     (swrst),
        .en_we     (wr_hit && (idx == RI_CAUSEEN)),
        .wdata     (host_wdata),
        .rd_cause  (rd_hit && (idx == RI_CAUSE)),
        .rd_err    (rd_hit && (idx == RI_ERROR)),
        .ev_cause  (ev_vec),
        .err_evt   (err_event),
        .irq_gate  (ctrl_w[CTL_GATE_BIT]),
        .cause_o   (cause_w),
        .en_o      (en_w),
        .err_o     (err_w),
        .pending_o (pending_w),
        .irq_o     (irq)
    );

    assign status_w = {fifo_one, fifo_two, (|err_w), 1'b0, sense_line, 1'b0, pending_w, mark_byte};

    always_comb begin
        case (idx)
            RI_DATA:    rd_mux = st_q.data;
            RI_TIMER:   rd_mux = count_w;
            RI_ERROR:   rd_mux = err_w;
            RI_MODE:    rd_mux = st_q.mode;
            RI_SELECT:  rd_mux = st_q.sel;
            RI_SETUP:   rd_mux = st_q.setup;
            RI_CTL_CLR: rd_mux = ctrl_w;
            RI_CTL_SET: rd_mux = status_w;
            RI_CAUSE:   rd_mux = 8'(cause_w);
            RI_NSTEP:   rd_mux = st_q.nstep;
            RI_TRACK:   rd_mux = st_q.track;
            RI_SECT:    rd_mux = st_q.sect;
            RI_GAPLEN:  rd_mux = st_q.gaplen;
            RI_TSECT:   rd_mux = st_q.tsect;
            RI_SCOUNT:  rd_mux = st_q.scount;
            RI_CAUSEEN: rd_mux = 8'(en_w);
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd_hit) st_d.rdata = rd_mux;
        if (wr_hit) begin
            case (idx)
                RI_DATA:   st_d.data   = host_wdata;
                RI_MODE:   st_d.mode   = host_wdata;
                RI_SELECT: st_d.sel    = host_wdata;
                RI_SETUP:  st_d.setup  = {1'b0, host_wdata[6:0]};
                RI_NSTEP:  st_d.nstep  = host_wdata;
                RI_TRACK:  st_d.track  = host_wdata;
                RI_SECT:   st_d.sect   = host_wdata;
                RI_GAPLEN: st_d.gaplen = host_wdata;
                RI_TSECT:  st_d.tsect  = host_wdata;
                RI_SCOUNT: st_d.scount = host_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;
    assign ctrl_out   = ctrl_w;
    assign select_out = st_q.sel;
    assign setup_out  = st_q.setup;

    assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(host_rdata));

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_out[CTL_GATE_BIT] && (en_w != '0)));

    assert_setup_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !setup_out[SETUP_RST_BIT]);

    assert_swreset_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> !irq);

endmodule

// File: tb/fdc_regbank_test.sv
module fdc_regbank_test;

    localparam int CPU = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic [7:0] host_rdata;
    logic       ev_data_changed = 0, ev_xfer_done = 0, ev_sector_seen = 0, ev_seek_done = 0;
    logic [7:0] err_event = '0;
    logic       fifo_one = 0, fifo_two = 0, sense_line = 0, mark_byte = 0;
    logic [7:0] ctrl_out, select_out, setup_out;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         pend = 0;

    always #4 clk = ~clk;

    fdc_regbank #(.CLKS_PER_US(CPU)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_data_changed(ev_data_changed), .ev_xfer_done(ev_xfer_done),
        .ev_sector_seen(ev_sector_seen), .ev_seek_done(ev_seek_done),
        .err_event(err_event), .fifo_one(fifo_one), .fifo_two(fifo_two),
        .sense_line(sense_line), .mark_byte(mark_byte),
        .ctrl_out(ctrl_out), .select_out(select_out), .setup_out(setup_out),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: a read driven in this cycle is compared one falling edge later
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) check("scoreboard-empty", 8'h00, 8'h01);
            else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
        end
        pend = host_sel && !host_wr;
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
        cyc();
        host_sel = 0; host_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        host_sel = 1; host_wr = 0; host_addr = a;
        cyc();
        host_sel = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // reset state
        check("R2 reset ctrl_out", ctrl_out, 8'h00);
        check("R4 reset irq", {7'd0, irq}, 8'h00);
        rd(8'h60, 8'h00, "R2 reset control");
        rd(8'h80, 8'h00, "R3 reset causes");
        rd(8'hF0, 8'h00, "R4 reset enable");

        // R9 / R1 plain registers and address low bits
        wr(8'h00, 8'h5A); wr(8'h33, 8'h95); wr(8'h40, 8'h0B);
        wr(8'h90, 8'h07); wr(8'hA0, 8'h4F); wr(8'hB0, 8'h12);
        wr(8'hC0, 8'h1B); wr(8'hDF, 8'h03); wr(8'hE0, 8'h09);
        rd(8'h0C, 8'h5A, "R9 data"); rd(8'h30, 8'h95, "R1 low addr bits ignored");
        rd(8'h40, 8'h0B, "R9 select"); rd(8'h90, 8'h07, "R9 nstep");
        rd(8'hA0, 8'h4F, "R9 track"); rd(8'hB0, 8'h12, "R9 sect");
        rd(8'hC0, 8'h1B, "R9 gap"); rd(8'hD0, 8'h03, "R9 tsect");
        rd(8'hE0, 8'h09, "R9 scount");
        check("R9 select_out", select_out, 8'h0B);
        cyc();
        check("R1 rdata holds", host_rdata, 8'h09);

        // R2 aliases
        wr(8'h70, 8'h83);
        check("R2 set alias", ctrl_out, 8'h83);
        wr(8'h60, 8'h02);
        check("R2 clear alias", ctrl_out, 8'h81);
        rd(8'h60, 8'h81, "R2 control readback");

        // R3 / R4 latch, gate, clear on read
        wr(8'hF0, 8'h04);
        ev_sector_seen = 1; cyc(); ev_sector_seen = 0;
        check("R4 irq on enabled cause", {7'd0, irq}, 8'h01);
        rd(8'h80, 8'h04, "R3 read sector cause");
        check("R3 irq drops after read", {7'd0, irq}, 8'h00);
        rd(8'h80, 8'h00, "R3 cleared");
        ev_seek_done = 1; cyc(); ev_seek_done = 0;
        check("R4 masked cause no irq", {7'd0, irq}, 8'h00);
        wr(8'h80, 8'hFF);
        rd(8'h80, 8'h02, "R4 write to causes ignored");
        wr(8'h60, 8'h01);
        ev_sector_seen = 1; cyc(); ev_sector_seen = 0;
        check("R4 gate off", {7'd0, irq}, 8'h00);
        wr(8'h70, 8'h01);
        check("R4 gate on", {7'd0, irq}, 8'h01);
        rd(8'h80, 8'h04, "R3 read");

        // R3 same-cycle arrival
        ev_data_changed = 1; cyc(); ev_data_changed = 0;
        ev_xfer_done = 1;
        rd(8'h80, 8'h10, "R3 read during event");
        ev_xfer_done = 0;
        rd(8'h80, 8'h08, "R3 event kept");

        // R5 / R7 errors and status
        err_event = 8'h41; cyc(); err_event = 8'h00;
        fifo_one = 1; sense_line = 1; mark_byte = 1;
        rd(8'h70, 8'hA9, "R7 status");
        fifo_one = 0; sense_line = 0; mark_byte = 0;
        rd(8'h20, 8'h41, "R5 error bits");
        rd(8'h20, 8'h00, "R5 error cleared");
        rd(8'h80, 8'h20, "R5 error cause");
        err_event = 8'hFF; cyc(); err_event = 8'h00;
        rd(8'h20, 8'hC5, "R5 mask");
        rd(8'h80, 8'h20, "R5 cause again");

        // R6 timer
        wr(8'hF0, 8'h01);
        wr(8'h10, 8'h05);
        repeat (19) cyc();
        check("R6 not yet expired", {7'd0, irq}, 8'h00);
        cyc();
        check("R6 expires on time", {7'd0, irq}, 8'h01);
        rd(8'h10, 8'h00, "R6 stopped at zero");
        rd(8'h80, 8'h01, "R6 timer cause");
        repeat (12) cyc();
        rd(8'h80, 8'h00, "R6 fires once");
        wr(8'h10, 8'h03);
        repeat (5) cyc();
        rd(8'h10, 8'h02, "R6 count readback");
        wr(8'h10, 8'h00);
        repeat (16) cyc();
        rd(8'h80, 8'h00, "R6 zero load no cause");

        // R8 software reset
        wr(8'h70, 8'hFF); wr(8'hF0, 8'h3F);
        ev_seek_done = 1; err_event = 8'h80; cyc(); ev_seek_done = 0; err_event = 8'h00;
        check("R8 irq before reset", {7'd0, irq}, 8'h01);
        wr(8'h50, 8'h85);
        check("R8 ctrl cleared", ctrl_out, 8'h00);
        check("R8 irq cleared", {7'd0, irq}, 8'h00);
        check("R8 setup_out", setup_out, 8'h05);
        rd(8'hF0, 8'h00, "R8 enable cleared");
        rd(8'h80, 8'h00, "R8 causes cleared");
        rd(8'h20, 8'h00, "R8 error cleared");
        rd(8'h50, 8'h05, "R8 setup readback");

        // R7 pending bit
        wr(8'hF0, 8'h02);
        ev_seek_done = 1; cyc(); ev_seek_done = 0;
        fifo_two = 1;
        rd(8'h70, 8'h42, "R7 pending and fifo_two");
        fifo_two = 0;
        cyc(); cyc();
        if (exp_q.size() != 0) check("scoreboard-drain", 8'(exp_q.size()), 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule